// File: doc/BRIEF.md
# IPI and Mailbox Send Dispatcher

This block takes 64-bit send commands that a core writes and turns each into one or two accesses on a target core's register space. There are three command kinds. An interrupt send sets one bit in the target's set register. A mailbox send writes one of eight mailbox words of the target. A free-address send writes any 16-bit address of the target's space. The target core is named by a 10-bit id carried in the command. The id is checked against a parameterised core count and a presence vector. A command naming no present core finishes with an error and touches nothing.

Mailbox and free-address sends carry a 4-bit byte-keep mask. When the mask is non-zero, the dispatcher first reads the target word. It then writes a merge: bytes whose mask bit is set keep their old value, and the other bytes come from the upper command word. One command is in flight at a time. The command port stalls through `cmd_ready_o` until the response beat has been given.

Top module: `ipi_send_dispatch`

## Requirements
- R1: The target core id is command bits 25:16. Every target access drives that id on `tgt_core_o`, and also on `tgt_rid_o` as the requester attribute.
- R2: If the id is not below NUM_CORES, or its `core_present_i` bit is 0, then a recognised command gives one response beat with `rsp_err_o`=1 and makes no target access.
- R3: A write to offset 0x040 (32- or 64-bit) is an interrupt send. It makes exactly one target write to offset 0x008 with data 1 << cmd[4:0]. It never reads, whatever bits 30:27 hold.
- R4: A 64-bit write to offset 0x048 is a mailbox send. Its target address is MBOX_BASE + 0x20 + (cmd & 0x1C).
- R5: A 64-bit write to offset 0x158 is a free-address send. Its target address is cmd[15:0].
- R6: For mailbox and free-address sends with keep mask cmd[30:27] non-zero, the block first reads the target address. It then writes a word in which byte i is the old byte if mask bit i is 1, and is otherwise byte i of cmd[63:32].
- R7: With a zero keep mask, no read is made, and cmd[63:32] is written unchanged.
- R8: Only the low 12 bits of `cmd_addr_i` are decoded. A mailbox or free-address send made as a 32-bit write, or a write to any other offset, gives one response beat without error and makes no target access.
- R9: A target request keeps `tgt_req_o`, `tgt_we_o`, `tgt_addr_o` and `tgt_wdata_o` steady until `tgt_gnt_i`. Each granted request is finished by one `tgt_rsp_i` beat.
- R10: `cmd_ready_o` is low from the cycle after a command is accepted until its single one-cycle `rsp_valid_o` beat has been given.
- R11: After reset, `cmd_ready_o`=1, `tgt_req_o`=0 and `rsp_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_ready_o | output | 1 | Dispatcher idle, command can be taken |
| cmd_addr_i | input | ADDR_W | Command write address (low 12 bits decoded) |
| cmd_wide_i | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| cmd_data_i | input | 64 | Command word |
| core_present_i | input | NUM_CORES | Per-core presence |
| rsp_valid_o | output | 1 | Command completion beat |
| rsp_err_o | output | 1 | Decode error on completion |
| tgt_req_o | output | 1 | Target access request |
| tgt_gnt_i | input | 1 | Target request accepted |
| tgt_we_o | output | 1 | 1 = write, 0 = read |
| tgt_core_o | output | 10 | Target core id |
| tgt_rid_o | output | 10 | Requester attribute of the access |
| tgt_addr_o | output | 16 | Target register address |
| tgt_wdata_o | output | 32 | Write data |
| tgt_rsp_i | input | 1 | Read data valid or write complete |
| tgt_rdata_i | input | 32 | Read data |

## Verification
The bench builds the block with NUM_CORES=4 and present mask 4'b1011. This makes in-range-but-absent cores, out-of-range ids and the largest 10-bit id all reachable in a handful of commands. At that size the bench can sweep all 32 interrupt vectors and every pairing of the eight mailbox slots with the sixteen keep masks. The free-address sends cover edge addresses under several masks. Grant latency cycles from 0 to 2 wait states, so the hold-until-grant rule runs against a stalling target.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;
  typedef enum logic [1:0] {K_NONE, K_IPI, K_MAIL, K_ANY} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_RESP} st_e;

  localparam int CORE_ID_W = 10;
  localparam int TADDR_W   = 16;
  localparam int WORD_W    = 32;
  localparam int KEEP_W    = WORD_W / 8;

  typedef struct packed {
    kind_e                 kind;
    logic                  err;
    logic [CORE_ID_W-1:0]  core;
    logic [TADDR_W-1:0]    addr;
    logic [KEEP_W-1:0]     keep;
    logic [WORD_W-1:0]     wdata;
  } op_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_disp_pkg::*;
#(
  parameter int          NUM_CORES = 256,
  parameter logic [11:0] IPI_OFF   = 12'h040,
  parameter logic [11:0] MAIL_OFF  = 12'h048,
  parameter logic [11:0] ANY_OFF   = 12'h158,
  parameter logic [15:0] SET_OFF   = 16'h0008,
  parameter logic [15:0] MBOX_BASE = 16'h0000
) (
  input  logic [11:0]          off_i,
  input  logic                 wide_i,
  input  logic [63:0]          data_i,
  input  logic [NUM_CORES-1:0] present_i,
  output op_t                  op_o
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam logic [CORE_ID_W-1:0] CORE_LIM = CORE_ID_W'(NUM_CORES);

  logic [CORE_ID_W-1:0] core;
  logic                 in_range, present;
  kind_e                kind;

  assign core     = data_i[25:16];
  assign in_range = (NUM_CORES >= 1024) || (core < CORE_LIM);
  assign present  = in_range && present_i[core[IDX_W-1:0]];

  always_comb begin
    kind = K_NONE;
    if (off_i == IPI_OFF)                kind = K_IPI;
    else if (off_i == MAIL_OFF && wide_i) kind = K_MAIL;
    else if (off_i == ANY_OFF && wide_i)  kind = K_ANY;
  end

  always_comb begin
    op_o       = '0;
    op_o.kind  = kind;
    op_o.core  = core;
    op_o.err   = (kind != K_NONE) && !present;
    op_o.wdata = data_i[63:32];
    op_o.keep  = data_i[30:27];
    unique case (kind)
      K_IPI: begin
        op_o.addr  = SET_OFF;
        op_o.keep  = '0;
        op_o.wdata = WORD_W'(1) << data_i[4:0];
      end
      K_MAIL:  op_o.addr = MBOX_BASE + 16'h0020 + {11'd0, data_i[4:2], 2'b00};
      K_ANY:   op_o.addr = data_i[15:0];
      default: op_o.keep = '0;
    endcase
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] old_i,
  input  logic [BYTES*8-1:0] new_i,
  input  logic [BYTES-1:0]   keep_i,
  output logic [BYTES*8-1:0] out_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign out_o[b*8 +: 8] = keep_i[b] ? old_i[b*8 +: 8] : new_i[b*8 +: 8];
  end
endmodule

// File: rtl/ipi_send_seq.sv
module ipi_send_seq
  import ipi_disp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  op_t                  op_i,
  output logic                 ready_o,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic                 tgt_req_o,
  input  logic                 tgt_gnt_i,
  output logic                 tgt_we_o,
  output logic [CORE_ID_W-1:0] tgt_core_o,
  output logic [TADDR_W-1:0]   tgt_addr_o,
  output logic [WORD_W-1:0]    tgt_wdata_o,
  input  logic                 tgt_rsp_i,
  input  logic [WORD_W-1:0]    tgt_rdata_i
);
  st_e               st_q;
  op_t               op_q;
  logic [WORD_W-1:0] old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      op_q  <= '0;
      old_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          op_q <= op_i;
          if (op_i.err || op_i.kind == K_NONE) st_q <= S_RESP;
          else if (op_i.keep != '0)            st_q <= S_RD_REQ;
          else                                 st_q <= S_WR_REQ;
        end
        S_RD_REQ:  if (tgt_gnt_i) st_q <= S_RD_WAIT;
        S_RD_WAIT: if (tgt_rsp_i) begin
          old_q <= tgt_rdata_i;
          st_q  <= S_WR_REQ;
        end
        S_WR_REQ:  if (tgt_gnt_i) st_q <= S_WR_WAIT;
        S_WR_WAIT: if (tgt_rsp_i) st_q <= S_RESP;
        S_RESP:    st_q <= S_IDLE;
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  // zero keep mask makes the merge a pass-through of the new word
  ipi_byte_merge #(.BYTES(KEEP_W)) u_merge (
    .old_i  (old_q),
    .new_i  (op_q.wdata),
    .keep_i (op_q.keep),
    .out_o  (tgt_wdata_o)
  );

  assign ready_o     = (st_q == S_IDLE);
  assign tgt_req_o   = (st_q == S_RD_REQ) || (st_q == S_WR_REQ);
  assign tgt_we_o    = (st_q == S_WR_REQ);
  assign tgt_core_o  = op_q.core;
  assign tgt_addr_o  = op_q.addr;
  assign rsp_valid_o = (st_q == S_RESP);
  assign rsp_err_o   = (st_q == S_RESP) && op_q.err;

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && !tgt_gnt_i |=> tgt_req_o && $stable(tgt_we_o) &&
                               $stable(tgt_addr_o) && $stable(tgt_wdata_o));
  a_r10_busy_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> !ready_o);
  a_r10_single_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && ready_o);
  a_r7_read_needs_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && !tgt_we_o |-> op_q.keep != '0);
  a_r3_ipi_onebit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && op_q.kind == K_IPI |-> tgt_we_o && $countones(tgt_wdata_o) == 1);
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_disp_pkg::*;
#(
  parameter int          NUM_CORES = 256,
  parameter int          ADDR_W    = 16,
  parameter logic [11:0] IPI_OFF   = 12'h040,
  parameter logic [11:0] MAIL_OFF  = 12'h048,
  parameter logic [11:0] ANY_OFF   = 12'h158,
  parameter logic [15:0] SET_OFF   = 16'h0008,
  parameter logic [15:0] MBOX_BASE = 16'h0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [ADDR_W-1:0]    cmd_addr_i,
  input  logic                 cmd_wide_i,
  input  logic [63:0]          cmd_data_i,
  input  logic [NUM_CORES-1:0] core_present_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic                 tgt_req_o,
  input  logic                 tgt_gnt_i,
  output logic                 tgt_we_o,
  output logic [9:0]           tgt_core_o,
  output logic [9:0]           tgt_rid_o,
  output logic [15:0]          tgt_addr_o,
  output logic [31:0]          tgt_wdata_o,
  input  logic                 tgt_rsp_i,
  input  logic [31:0]          tgt_rdata_i
);
  op_t  dec_op;
  logic start;

  ipi_cmd_decode #(
    .NUM_CORES (NUM_CORES),
    .IPI_OFF   (IPI_OFF),
    .MAIL_OFF  (MAIL_OFF),
    .ANY_OFF   (ANY_OFF),
    .SET_OFF   (SET_OFF),
    .MBOX_BASE (MBOX_BASE)
  ) u_dec (
    .off_i     (cmd_addr_i[11:0]),
    .wide_i    (cmd_wide_i),
    .data_i    (cmd_data_i),
    .present_i (core_present_i),
    .op_o      (dec_op)
  );

  assign start = cmd_valid_i && cmd_ready_o;

  ipi_send_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .op_i        (dec_op),
    .ready_o     (cmd_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .tgt_req_o   (tgt_req_o),
    .tgt_gnt_i   (tgt_gnt_i),
    .tgt_we_o    (tgt_we_o),
    .tgt_core_o  (tgt_core_o),
    .tgt_addr_o  (tgt_addr_o),
    .tgt_wdata_o (tgt_wdata_o),
    .tgt_rsp_i   (tgt_rsp_i),
    .tgt_rdata_i (tgt_rdata_i)
  );

  assign tgt_rid_o = tgt_core_o;

  if (ADDR_W > 12) begin : g_unused_addr
    logic unused_hi;
    assign unused_hi = ^cmd_addr_i[ADDR_W-1:12];
  end

  a_r2_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && dec_op.err |=> rsp_valid_o && rsp_err_o && !tgt_req_o);
  a_r8_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && dec_op.kind == K_NONE |=> rsp_valid_o && !rsp_err_o && !tgt_req_o);
  a_r1_rid_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && !dec_op.err && dec_op.kind != K_NONE |=> tgt_req_o && tgt_core_o == $past(cmd_data_i[25:16]));
endmodule

// File: tb/tb_ipi_send_dispatch.sv
`timescale 1ns/1ps
module tb_ipi_send_dispatch;
  localparam int NC = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [15:0] cmd_addr = '0;
  logic        cmd_wide = 0;
  logic [63:0] cmd_data = '0;
  logic [NC-1:0] present = 4'b1011;
  logic        rsp_valid, rsp_err;
  logic        tgt_req, tgt_gnt, tgt_we, tgt_rsp;
  logic [9:0]  tgt_core, tgt_rid;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata, tgt_rdata;

  int checks = 0, fails = 0;
  int stall = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  ipi_send_dispatch #(.NUM_CORES(NC)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_wide_i(cmd_wide), .cmd_data_i(cmd_data),
    .core_present_i(present),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .tgt_req_o(tgt_req), .tgt_gnt_i(tgt_gnt), .tgt_we_o(tgt_we),
    .tgt_core_o(tgt_core), .tgt_rid_o(tgt_rid), .tgt_addr_o(tgt_addr),
    .tgt_wdata_o(tgt_wdata), .tgt_rsp_i(tgt_rsp), .tgt_rdata_i(tgt_rdata)
  );

  function automatic logic [31:0] pat(input logic [9:0] c, input logic [15:0] a);
    return {a ^ 16'hC3A5, 6'h2B, c};
  endfunction

  // target model: grant after `stall` wait cycles, response one cycle later
  int hold_cnt = 0;
  assign tgt_gnt = tgt_req && (hold_cnt >= stall);
  int rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0;
  logic [15:0] r_addr, w_addr;
  logic [31:0] w_data;
  logic [9:0]  r_core, w_core, w_rid;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    hold_cnt <= (tgt_req && !tgt_gnt) ? hold_cnt + 1 : 0;
    tgt_rsp <= 1'b0;
    if (rst_n && tgt_req && tgt_gnt) begin
      tgt_rsp <= 1'b1;
      if (tgt_we) begin
        wr_cnt <= wr_cnt + 1; w_addr <= tgt_addr; w_data <= tgt_wdata;
        w_core <= tgt_core; w_rid <= tgt_rid;
      end else begin
        rd_cnt <= rd_cnt + 1; r_addr <= tgt_addr; r_core <= tgt_core;
        tgt_rdata <= pat(tgt_core, tgt_addr);
      end
    end
    if (rst_n && rsp_valid) rsp_cnt <= rsp_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [9:0] c, input logic [3:0] keep,
                                     input logic [31:0] hi, input logic [15:0] lo);
    return {hi, 1'b0, keep, 1'b0, c, lo};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] keep);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = keep[i] ? 8'hFF : 8'h00;
    return (old & m) | (nw & ~m);
  endfunction

  // exp_acc: 0 = none, 1 = write only, 2 = read then write
  task automatic run(input logic [15:0] a, input bit wide, input logic [63:0] d,
                     input int st, input bit exp_err, input int exp_acc,
                     input logic [15:0] exp_addr, input logic [31:0] exp_wd,
                     input string req);
    int rd0, wr0, rs0, n;
    bit seen;
    rd0 = rd_cnt; wr0 = wr_cnt; rs0 = rsp_cnt;
    stall = st;
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_wide = wide; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 0, "R10", "ready after accept", 64'(cmd_ready), 64'd0);
    seen = 0; n = 0;
    while (!seen && n < 40) begin
      if (rsp_valid) seen = 1;
      else begin @(negedge clk); n++; end
    end
    chk(seen, req, "response seen", 64'(seen), 64'd1);
    chk(rsp_err == exp_err, exp_err ? "R2" : req, "rsp_err", 64'(rsp_err), 64'(exp_err));
    @(negedge clk);
    chk(!rsp_valid && rsp_cnt - rs0 == 1, "R10", "single rsp beat",
        64'(rsp_cnt - rs0), 64'd1);
    chk(rd_cnt - rd0 == (exp_acc == 2 ? 1 : 0), exp_acc == 2 ? "R6" : "R7",
        "read count", 64'(rd_cnt - rd0), 64'(exp_acc == 2));
    chk(wr_cnt - wr0 == (exp_acc != 0 ? 1 : 0), exp_acc == 0 ? "R8" : req,
        "write count", 64'(wr_cnt - wr0), 64'(exp_acc != 0));
    if (exp_acc == 2)
      chk(r_addr == exp_addr && r_core == d[25:16], "R6", "read addr/core",
          {r_core, r_addr}, {d[25:16], exp_addr});
    if (exp_acc != 0) begin
      chk(w_addr == exp_addr, req, "write addr", 64'(w_addr), 64'(exp_addr));
      chk(w_data == exp_wd, req, "write data", 64'(w_data), 64'(exp_wd));
      chk(w_core == d[25:16] && w_rid == d[25:16], "R1", "core/rid",
          {w_rid, w_core}, {d[25:16], d[25:16]});
    end
  endtask

  initial begin
    #1;
    chk(cmd_ready == 1 && !tgt_req && !rsp_valid, "R11", "reset outputs",
        {cmd_ready, tgt_req, rsp_valid}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1 && !tgt_req && !rsp_valid, "R11", "after reset",
        {cmd_ready, tgt_req, rsp_valid}, 3'b100);

    // R3: every vector; mask bits set but no read; high address bits ignored (R8)
    for (int v = 0; v < 32; v++) begin
      logic [63:0] d;
      d = mk(10'd0, 4'(v), 32'hDEAD_0000 | 32'(v), {11'h2A5, 5'(v)});
      run(16'hF040, v[0], d, v % 3, 0, 1, 16'h0008, 32'd1 << v, "R3");
    end

    // R4 R6 R7: all slots x all keep masks
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 16; k++) begin
        logic [9:0] c;
        logic [63:0] d;
        logic [15:0] ea;
        logic [31:0] hi;
        c  = (k % 2) ? 10'd3 : 10'd1;
        hi = 32'h1122_3344 ^ {4'(k), 12'h0, 8'(s), 8'(s * 17)};
        d  = mk(c, 4'(k), hi, {8'h5A, 3'b101, 3'(s), 2'b11});
        ea = 16'h0020 + 16'(s * 4);
        run(16'h0048, 1, d, (s + k) % 3, 0, (k != 0) ? 2 : 1, ea,
            merge(pat(c, ea), hi, 4'(k)), (k != 0) ? "R6" : "R4");
      end
    end

    // R5: free addresses under several masks
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [15:0] ta;
        logic [3:0]  km;
        logic [31:0] hi;
        ta = (i == 0) ? 16'h0000 : (i == 1) ? 16'h1234 : (i == 2) ? 16'hFFFC : 16'h8001;
        km = (j == 0) ? 4'h0 : (j == 1) ? 4'h1 : (j == 2) ? 4'h6 : 4'hF;
        hi = 32'hA0B0_C0D0 + 32'(i * 16 + j);
        run(16'h0158, 1, mk(10'd3, km, hi, ta), j % 3, 0, (km != 0) ? 2 : 1, ta,
            merge(pat(10'd3, ta), hi, km), "R5");
      end
    end

    // R2: absent, out-of-range and largest ids for each kind
    for (int i = 0; i < 4; i++) begin
      logic [9:0] c;
      c = (i == 0) ? 10'd2 : (i == 1) ? 10'd4 : (i == 2) ? 10'd5 : 10'd1023;
      run(16'h0040, 0, mk(c, 4'h0, 32'h1, 16'h3), 0, 1, 0, '0, '0, "R2");
      run(16'h0048, 1, mk(c, 4'h3, 32'h2, 16'h4), 0, 1, 0, '0, '0, "R2");
      run(16'h0158, 1, mk(c, 4'h0, 32'h3, 16'h10), 0, 1, 0, '0, '0, "R2");
    end

    // R8: narrow mail/any, unknown offset, also with absent core
    run(16'h0048, 0, mk(10'd1, 4'h0, 32'h5, 16'h4), 0, 0, 0, '0, '0, "R8");
    run(16'h0158, 0, mk(10'd1, 4'h2, 32'h6, 16'h8), 0, 0, 0, '0, '0, "R8");
    run(16'h0100, 1, mk(10'd1, 4'h0, 32'h7, 16'h8), 0, 0, 0, '0, '0, "R8");
    run(16'h0100, 1, mk(10'd2, 4'h0, 32'h7, 16'h8), 0, 0, 0, '0, '0, "R8");
    run(16'h1158, 1, mk(10'd0, 4'h0, 32'h9, 16'h44), 2, 0, 1, 16'h0044, 32'h9, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule